// File: doc/BRIEF.md
# Bit-Serial Fixed-Point Square Root

This unit takes one unsigned fixed-point operand and returns its square root, also in fixed point. It works one root bit per clock cycle, starting at the most significant bit. In each cycle it squares the whole trial root with a multiplier and compares that square with the operand. The result of the compare decides whether the current trial bit stays set, and the next lower bit is then tried. A zero operand, or an operand whose square root is exact at the current trial, ends the computation early.

Two elaboration-time parameters fix the widths. `INT_P` sets the integer width: the operand has 2·(INT_P−1) integer bits and the root has INT_P−1. `FRAC_P` sets the number of fractional bits, which both the operand and the root carry. The root's square has twice as many fractional bits as the root. For this reason the unit shifts the operand left by `FRAC_P` places when it captures it, so that both sides of the compare share one binary point.

An operand comes in on a valid/ready pair. `in_ready` is high only while the unit is idle. While it is busy, any operand offered is simply not taken: the source holds it, or withdraws it, and the unit keeps the one already in progress. The result leaves through a one-cycle `done` pulse, and `root` holds that value until the next result. The output side has no back-pressure, so a consumer must take the root on `done` or at any later time before it issues a new operand.

Top module: `sa_sqrt_top`

## Requirements
- R1: The operand `in_operand` is 2·(INT_P−1)+FRAC_P bits wide, with its binary point FRAC_P bits above bit 0. The root `root` is (INT_P−1)+FRAC_P bits wide, also with FRAC_P fractional bits. For example, the operand 1.0 (value 1<<FRAC_P) yields the root 1.0 (value 1<<FRAC_P).
- R2: Read the operand S and the root r as integers, and let T = S·2^FRAC_P. Every result satisfies r² ≤ T < (r+1)², so r is correct to within one unit in its last place.
- R3: When the unit accepts a zero operand, `done` is high in the cycle right after the accepting edge, with `root` = 0, and `busy` never rises.
- R4: When the unit accepts a nonzero operand whose exact root r satisfies r² = T, the computation stops early. Let b be the position of the lowest set bit of r. Then `done` is high after the (ROOT_W−b)-th edge that follows the accepting edge.
- R5: When the unit accepts any other nonzero operand, `done` is high after exactly the ROOT_W-th edge that follows the accepting edge. No operand takes longer than INT_P+FRAC_P+3 cycles.
- R6: `in_ready` is high only while the unit is idle. `busy` is high from the cycle after a nonzero operand is accepted until its result. An operand offered while `in_ready` is low is not taken: it does not change the result in progress, and it produces no further `done`.
- R7: `done` is a single-cycle pulse for each accepted operand. `root` changes only in a cycle where `done` is high, and it holds its value in all other cycles.
- R8: After reset, `in_ready` = 1, `busy` = 0, `done` = 0 and `root` = 0.
- R9: The all-ones operand yields the all-ones root.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit idle; operand taken when valid and ready |
| in_operand | input | 2·(INT_P−1)+FRAC_P | Unsigned fixed-point operand |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle pulse: `root` is new |
| root | output | (INT_P−1)+FRAC_P | Unsigned fixed-point square root, held between results |

## Verification
The bench goes after the cases where the trial-bit update is most easily wrong. With the all-ones operand and random operands, a unit that failed to clear a bit after an over-large square, or that mishandled bit 0, would return a root whose square lands outside the R2 bracket. Exact squares with trailing zero bits check the early exit: a unit that missed the equality would run the full ROOT_W cycles, and one that stopped on the wrong compare would stop with a wrong root. A zero operand must finish at once without raising `busy`. Operands offered while busy must produce neither a second pulse nor a corrupted result, which would show up if `in_ready` were not held low during the computation.

// File: rtl/sa_sqrt_pkg.sv
package sa_sqrt_pkg;

  // outcome of comparing the squared trial root against the aligned operand
  typedef enum logic [1:0] {
    REL_LT = 2'd0,
    REL_EQ = 2'd1,
    REL_GT = 2'd2
  } rel_t;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;

  // width of a bit-position index over w positions (at least one bit)
  function automatic int idx_bits(input int w);
    return (w < 2) ? 1 : $clog2(w);
  endfunction

endpackage

// File: rtl/sa_sqrt_sq_cmp.sv
module sa_sqrt_sq_cmp
  import sa_sqrt_pkg::*;
#(
  parameter int ROOT_W = 8,
  parameter int SQ_W   = 2 * ROOT_W
) (
  input  logic [ROOT_W-1:0] trial,
  input  logic [SQ_W-1:0]   target,
  output rel_t              rel
);

  logic [SQ_W-1:0] sq;

  // full square of the trial root; SQ_W holds it without loss
  assign sq = SQ_W'(trial) * SQ_W'(trial);

  always_comb begin
    if (sq == target)     rel = REL_EQ;
    else if (sq > target) rel = REL_GT;
    else                  rel = REL_LT;
  end

endmodule

// File: rtl/sa_sqrt_trial.sv
module sa_sqrt_trial #(
  parameter int ROOT_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              clr_cur,
  output logic [ROOT_W-1:0] trial,
  output logic [ROOT_W-1:0] trial_nxt,
  output logic              idx_last
);

  localparam logic [ROOT_W-1:0] TOP_ONE = {1'b1, {(ROOT_W-1){1'b0}}};
  localparam logic [IDX_W-1:0]  TOP_IDX = IDX_W'(ROOT_W - 1);

  logic [ROOT_W-1:0] trial_q;
  logic [IDX_W-1:0]  idx_q;

  assign trial    = trial_q;
  assign idx_last = (idx_q == '0);

  // drop the bit under test if the square overshot, then arm the next lower bit
  always_comb begin
    trial_nxt = trial_q;
    for (int b = 0; b < ROOT_W; b++) begin
      if ((b == int'(idx_q)) && clr_cur) trial_nxt[b] = 1'b0;
      if ((b + 1) == int'(idx_q))        trial_nxt[b] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      idx_q   <= '0;
    end else if (load) begin
      trial_q <= TOP_ONE;
      idx_q   <= TOP_IDX;
    end else if (step) begin
      trial_q <= trial_nxt;
      if (!idx_last) idx_q <= idx_q - 1'b1;
    end
  end

endmodule

// File: rtl/sa_sqrt_fsm.sv
module sa_sqrt_fsm
  import sa_sqrt_pkg::*;
#(
  parameter int OP_W   = 12,
  parameter int FRAC_W = 4,
  parameter int ROOT_W = 8,
  parameter int SQ_W   = 2 * ROOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_operand,
  input  rel_t              rel,
  input  logic              idx_last,
  input  logic [ROOT_W-1:0] trial,
  input  logic [ROOT_W-1:0] trial_nxt,
  output logic              in_ready,
  output logic              busy,
  output logic              done,
  output logic [ROOT_W-1:0] root,
  output logic [SQ_W-1:0]   target,
  output logic              load,
  output logic              step,
  output logic              clr_cur
);

  phase_t            ph_q;
  logic              done_q;
  logic [ROOT_W-1:0] root_q;
  logic [SQ_W-1:0]   target_q;
  logic              accept;
  logic              op_zero;

  assign in_ready = (ph_q == PH_IDLE);
  assign busy     = (ph_q == PH_RUN);
  assign done     = done_q;
  assign root     = root_q;
  assign target   = target_q;

  assign accept  = in_valid && in_ready;
  assign op_zero = (in_operand == '0);
  assign load    = accept && !op_zero;
  assign step    = busy && (rel != REL_EQ);
  assign clr_cur = (rel == REL_GT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      done_q   <= 1'b0;
      root_q   <= '0;
      target_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: begin
          if (accept) begin
            // align the operand to the square's 2*FRAC_W fractional bits
            target_q <= SQ_W'(in_operand) << FRAC_W;
            if (op_zero) begin
              root_q <= '0;
              done_q <= 1'b1;
            end else begin
              ph_q <= PH_RUN;
            end
          end
        end
        PH_RUN: begin
          if (rel == REL_EQ) begin
            root_q <= trial;
            done_q <= 1'b1;
            ph_q   <= PH_IDLE;
          end else if (idx_last) begin
            root_q <= trial_nxt;
            done_q <= 1'b1;
            ph_q   <= PH_IDLE;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sa_sqrt_top.sv
module sa_sqrt_top
  import sa_sqrt_pkg::*;
#(
  parameter int INT_P  = 5,
  parameter int FRAC_P = 4,
  localparam int ROOT_W = INT_P - 1 + FRAC_P,
  localparam int OP_W   = 2 * (INT_P - 1) + FRAC_P
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_operand,
  output logic              busy,
  output logic              done,
  output logic [ROOT_W-1:0] root
);

  localparam int SQ_W  = 2 * ROOT_W;
  localparam int IDX_W = idx_bits(ROOT_W);

  rel_t              rel;
  logic [SQ_W-1:0]   target;
  logic [ROOT_W-1:0] trial;
  logic [ROOT_W-1:0] trial_nxt;
  logic              idx_last;
  logic              load;
  logic              step;
  logic              clr_cur;

  sa_sqrt_sq_cmp #(
    .ROOT_W (ROOT_W),
    .SQ_W   (SQ_W)
  ) cmp_i (
    .trial  (trial),
    .target (target),
    .rel    (rel)
  );

  sa_sqrt_trial #(
    .ROOT_W (ROOT_W),
    .IDX_W  (IDX_W)
  ) trial_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (step),
    .clr_cur   (clr_cur),
    .trial     (trial),
    .trial_nxt (trial_nxt),
    .idx_last  (idx_last)
  );

  sa_sqrt_fsm #(
    .OP_W   (OP_W),
    .FRAC_W (FRAC_P),
    .ROOT_W (ROOT_W),
    .SQ_W   (SQ_W)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_operand (in_operand),
    .rel        (rel),
    .idx_last   (idx_last),
    .trial      (trial),
    .trial_nxt  (trial_nxt),
    .in_ready   (in_ready),
    .busy       (busy),
    .done       (done),
    .root       (root),
    .target     (target),
    .load       (load),
    .step       (step),
    .clr_cur    (clr_cur)
  );

endmodule

// File: rtl/sa_sqrt_chk.sv
module sa_sqrt_chk #(
  parameter int INT_P  = 5,
  parameter int FRAC_P = 4,
  localparam int ROOT_W = INT_P - 1 + FRAC_P,
  localparam int OP_W   = 2 * (INT_P - 1) + FRAC_P
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OP_W-1:0]   in_operand,
  input logic              busy,
  input logic              done,
  input logic [ROOT_W-1:0] root
);

  localparam int XW = 2 * ROOT_W + 2;
  localparam int CW = $clog2(ROOT_W + 1) + 1;

  logic [OP_W-1:0] op_cap;
  logic [CW-1:0]   run_cnt;
  logic [XW-1:0]   tgt_x;
  logic [XW-1:0]   lo_sq;
  logic [XW-1:0]   hi_sq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_cap  <= '0;
      run_cnt <= '0;
    end else begin
      if (in_valid && in_ready) op_cap <= in_operand;
      run_cnt <= busy ? run_cnt + 1'b1 : '0;
    end
  end

  assign tgt_x = XW'(op_cap) << FRAC_P;
  assign lo_sq = XW'(root) * XW'(root);
  assign hi_sq = (XW'(root) + 1'b1) * (XW'(root) + 1'b1);

  AST_ROOT_BRACKET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((lo_sq <= tgt_x) && (tgt_x < hi_sq))); // R2

  AST_ZERO_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_operand == '0)) |=> (done && (root == '0) && !busy)); // R3

  AST_RUN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt < CW'(ROOT_W))); // R5

  AST_TAKE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_operand != '0)) |=> busy); // R6

  AST_NO_PULSE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done); // R7

  AST_ROOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(root)); // R7

endmodule

bind sa_sqrt_top sa_sqrt_chk #(.INT_P(INT_P), .FRAC_P(FRAC_P)) chk_i (.*);

// File: tb/sa_sqrt_harness.sv
module sa_sqrt_harness #(
  parameter int INT_P  = 5,
  parameter int FRAC_P = 4,
  parameter int SEED   = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic fin
);

  localparam int ROOT_W = INT_P - 1 + FRAC_P;
  localparam int OP_W   = 2 * (INT_P - 1) + FRAC_P;
  localparam longint OP_MASK = (64'sd1 <<< OP_W) - 1;

  logic              in_valid;
  logic              in_ready;
  logic [OP_W-1:0]   in_operand;
  logic              busy;
  logic              done;
  logic [ROOT_W-1:0] root;

  int n_chk = 0;
  int n_bad = 0;

  sa_sqrt_top #(.INT_P(INT_P), .FRAC_P(FRAC_P)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_operand (in_operand),
    .busy       (busy),
    .done       (done),
    .root       (root)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s [INT_P=%0d FRAC_P=%0d] actual %0d expected %0d",
               req, INT_P, FRAC_P, act, exp);
    end
  endtask

  function automatic longint ref_root(input longint s);
    longint t = s <<< FRAC_P;
    longint r = longint'($floor($sqrt(real'(t))));
    while (r * r > t) r--;
    while ((r + 1) * (r + 1) <= t) r++;
    return r;
  endfunction

  function automatic int ref_lat(input longint s, input longint r);
    if (s == 0) return 0;
    if (r * r == (s <<< FRAC_P)) begin
      for (int b = 0; b < ROOT_W; b++)
        if (((r >>> b) & 1) == 1) return ROOT_W - b;
    end
    return ROOT_W;
  endfunction

  task automatic run_op(input longint s, input string req);
    longint exp_r = ref_root(s);
    int     exp_l = ref_lat(s, exp_r);
    int     lat   = 0;
    string  ltag;
    @(negedge clk);
    in_valid   = 1'b1;
    in_operand = OP_W'(s);
    @(negedge clk);
    in_valid = 1'b0;
    if (s != 0) chk(busy === 1'b1, "R6", longint'(busy), 1);
    else        chk(busy === 1'b0, "R3", longint'(busy), 0);
    while (!done && lat < ROOT_W + 8) begin
      @(negedge clk);
      lat++;
    end
    chk(longint'(root) == exp_r, req, longint'(root), exp_r);
    ltag = (s == 0) ? "R3" : ((exp_l == ROOT_W) ? "R5" : "R4");
    chk(lat == exp_l, ltag, lat, exp_l);
    chk(lat <= INT_P + FRAC_P + 3, "R5", lat, INT_P + FRAC_P + 3);
    @(negedge clk);
    chk(!done && longint'(root) == exp_r, "R7", longint'(done), 0);
  endtask

  task automatic busy_offer(input longint a, input longint b);
    longint exp_r = ref_root(a);
    int     lat   = 0;
    int     extra = 0;
    @(negedge clk);
    in_valid   = 1'b1;
    in_operand = OP_W'(a);
    @(negedge clk);
    in_operand = OP_W'(b);
    chk(in_ready === 1'b0, "R6", longint'(in_ready), 0);
    @(negedge clk);
    chk(in_ready === 1'b0, "R6", longint'(in_ready), 0);
    in_valid = 1'b0;
    while (!done && lat < ROOT_W + 8) begin
      @(negedge clk);
      lat++;
    end
    chk(longint'(root) == exp_r, "R6", longint'(root), exp_r);
    for (int k = 0; k < 2 * ROOT_W + 4; k++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk(extra == 0, "R6", extra, 0);
    chk(longint'(root) == exp_r, "R7", longint'(root), exp_r);
  endtask

  initial begin
    longint s;
    longint r;
    int     h;
    fin        = 1'b0;
    in_valid   = 1'b0;
    in_operand = '0;
    void'($urandom(SEED));
    wait (rst_n === 1'b1);
    @(negedge clk);
    // R8 reset state
    chk(in_ready === 1'b1 && busy === 1'b0 && done === 1'b0 && root == '0,
        "R8", longint'(root), 0);
    // R1 widths and binary point
    chk($bits(in_operand) == 2 * (INT_P - 1) + FRAC_P, "R1", $bits(in_operand), OP_W);
    chk($bits(root) == INT_P - 1 + FRAC_P, "R1", $bits(root), ROOT_W);
    run_op(64'sd1 <<< FRAC_P, "R1");
    if (INT_P >= 3) run_op(64'sd4 <<< FRAC_P, "R1");
    run_op(0, "R3");
    // R4 exact squares with varied trailing zeros
    h = (FRAC_P + 1) / 2;
    run_op(((64'sd1 <<< (ROOT_W - 1)) * (64'sd1 <<< (ROOT_W - 1))) >>> FRAC_P, "R4");
    for (int i = 0; i < 10; i++) begin
      r = longint'($urandom % (32'd1 << (ROOT_W - h)));
      if (r == 0) r = 1;
      r = r <<< h;
      run_op((r * r) >>> FRAC_P, "R4");
    end
    run_op(OP_MASK, "R9");
    run_op(1, "R2");
    run_op(OP_MASK - 1, "R2");
    for (int i = 0; i < 40; i++) begin
      s = longint'({$urandom, $urandom}) & OP_MASK;
      run_op(s, "R2");
    end
    busy_offer(OP_MASK, 64'sd1 <<< FRAC_P);
    run_op(0, "R3");
    fin = 1'b1;
  end

endmodule

// File: tb/sa_sqrt_top_tb_top.sv
`timescale 1ns/1ps
module sa_sqrt_top_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fin_a;
  logic fin_b;

  always #4 clk = ~clk;

  sa_sqrt_harness #(.INT_P(5), .FRAC_P(4), .SEED(11)) h_a (
    .clk (clk), .rst_n (rst_n), .fin (fin_a)
  );

  sa_sqrt_harness #(.INT_P(9), .FRAC_P(6), .SEED(23)) h_b (
    .clk (clk), .rst_n (rst_n), .fin (fin_b)
  );

  initial begin
    int cyc = 0;
    int tot = 0;
    int bad = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    while (!(fin_a === 1'b1 && fin_b === 1'b1) && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    tot = h_a.n_chk + h_b.n_chk;
    bad = h_a.n_bad + h_b.n_bad;
    if (!(fin_a === 1'b1 && fin_b === 1'b1)) begin
      tot++;
      bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", tot, bad);
    $finish;
  end

endmodule